// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block sits between a synchronous host request port and an external asynchronous static RAM of 262,144 bytes. The host presents one request at a time, either a read or a write with an 18-bit address and 8-bit data. The controller turns each request into a pin sequence on the memory side. That sequence has a chip-select pair of opposite polarity, a write strobe and an output-enable strobe. The controller also runs the shared data bus through separate drive, drive-enable and receive signals.

Every timing interval is a whole number of system clocks. Each one comes from the nanosecond figure of the selected speed grade and is rounded up by the clock period, so the same code can run at other clock rates. A read holds the memory selected with outputs enabled until every access time has elapsed. The data is then captured and flagged for one clock, and a turnaround gap follows. A write uses one setup clock, then a counted write-strobe pulse, then a hold clock. The address and data stay stable across the whole write window.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, until a request arrives: ready is high, the memory is deselected (`mem_ce_n`=1, `mem_ce`=0), `mem_we_n`=1, `mem_oe_n`=1, the bus is not driven and `rsp_valid`=0.
- R2: A request is taken only on a clock edge where both `req_valid` and `req_ready` are high. After that, ready stays low for ACC+TURN clocks on a read and WLOW+2 clocks on a write. At the 70 ns grade with a 10 ns clock these are 7+4 and 6+2. A request held while ready is low changes no memory pin.
- R3: For the ACC clocks after a read is taken, both enables are active, `mem_oe_n`=0, `mem_we_n`=1 and `mem_addr` equals the request address.
- R4: Read data is captured on the edge that ends the access interval. At that edge at least the address, select and output-enable access times have elapsed. `rsp_valid` is high for exactly one clock, and `rsp_rdata` is valid during that clock.
- R5: After a read, output enable is high and the memory is deselected for TURN clocks before the next request is taken. The controller's drivers never switch on within the memory's output-disable time.
- R6: A write is laid out in clock order. First comes a setup clock: selected, bus driven with the write data, `mem_we_n`=1. Next come WLOW clocks with `mem_we_n`=0. Last comes a hold clock: still selected and driven, `mem_we_n`=1. The write window satisfies the pulse-width, select-to-end, address-to-end and data-setup minimums.
- R7: The controller drives the bus only while `mem_oe_n` is high.
- R8: `mem_addr` changes only while `mem_we_n` is high, and only if it was also high in the clock before.
- R9: The two chip enables always switch together, so `mem_ce_n` equals the inverse of `mem_ce`.
- R10: A read returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller can take a request this clock |
| rsp_rdata | output | 8 | Captured read data |
| rsp_valid | output | 1 | One-clock strobe marking `rsp_rdata` |
| mem_addr | output | 18 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ce | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's bus drivers |
| mem_dq_in | input | 8 | Data received from the bus |

## Verification
Two functions share one edge. The edge that captures read data also raises output enable and deselects the memory. The edge that brings ready back can also take a request that the host has held during the busy cycle. The bench holds a request through the busy time of a previous read and issues writes right after reads. A behavioural memory model returns corrupted data when sampled early and times every strobe in nanoseconds. A reference queue compares each pin on every clock, which judges both the capture value and the exact cycle in which the turnaround gap ends and the held request is taken.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    // Sequencer states for one memory access.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } seq_state_e;

    // Pin levels requested for the next clock, all active high.
    typedef struct packed {
        logic sel;
        logic oe_low;
        logic we_low;
        logic drive;
    } pin_cmd_t;

    // Nanoseconds to whole clocks, rounded up.
    function automatic int clk_ceil(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pick the fast or slow grade figure.
    function automatic int grade_ns(input int slow, input int fast_ns, input int slow_ns);
        return (slow != 0) ? slow_ns : fast_ns;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
// Down-counter for the interval of one phase.
// Assumes the sequencer loads it on entry to a phase and asks it to
// step while the phase is running; zero marks the last clock of the phase.
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    // Load has priority over stepping, and the count stops at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_seq.sv
// Access sequencer: takes host requests and decides the memory pin levels
// for the following clock. A read is ACC clocks of access and then TURN
// clocks of turnaround. A write is one setup clock, WLOW clocks of strobe
// and one hold clock. Assumes the pin stage registers the command.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int ACC_CLK  = 7,
    parameter int TURN_CLK = 4,
    parameter int WLOW_CLK = 6,
    parameter int CNT_W    = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     req_write,
    output logic     ready,
    output logic     accept,
    output pin_cmd_t cmd_nxt,
    output logic     capture
);
    localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CLK - 1);
    localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CLK - 1);
    localparam logic [CNT_W-1:0] WLOW_LD = CNT_W'(WLOW_CLK - 1);

    seq_state_e       st_q, st_d;
    logic             t_load, t_dec, t_zero;
    logic [CNT_W-1:0] t_val;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .dec      (t_dec),
        .zero     (t_zero)
    );

    assign ready  = (st_q == ST_IDLE);
    assign accept = ready && req_valid;

    // Next state, timer control and pin command for the next clock.
    always_comb begin
        st_d    = st_q;
        cmd_nxt = '0;
        t_load  = 1'b0;
        t_val   = '0;
        t_dec   = 1'b0;
        capture = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (accept && req_write) begin
                    cmd_nxt.sel   = 1'b1;
                    cmd_nxt.drive = 1'b1;
                    st_d          = ST_WR_SETUP;
                end else if (accept) begin
                    cmd_nxt.sel    = 1'b1;
                    cmd_nxt.oe_low = 1'b1;
                    t_load         = 1'b1;
                    t_val          = ACC_LD;
                    st_d           = ST_RD_ACC;
                end
            end
            ST_RD_ACC: begin
                if (t_zero) begin
                    capture = 1'b1;
                    t_load  = 1'b1;
                    t_val   = TURN_LD;
                    st_d    = ST_RD_TURN;
                end else begin
                    cmd_nxt.sel    = 1'b1;
                    cmd_nxt.oe_low = 1'b1;
                    t_dec          = 1'b1;
                end
            end
            ST_RD_TURN: begin
                if (t_zero) begin
                    st_d = ST_IDLE;
                end else begin
                    t_dec = 1'b1;
                end
            end
            ST_WR_SETUP: begin
                cmd_nxt.sel    = 1'b1;
                cmd_nxt.drive  = 1'b1;
                cmd_nxt.we_low = 1'b1;
                t_load         = 1'b1;
                t_val          = WLOW_LD;
                st_d           = ST_WR_PULSE;
            end
            ST_WR_PULSE: begin
                cmd_nxt.sel   = 1'b1;
                cmd_nxt.drive = 1'b1;
                if (t_zero) begin
                    st_d = ST_WR_HOLD;
                end else begin
                    cmd_nxt.we_low = 1'b1;
                    t_dec          = 1'b1;
                end
            end
            ST_WR_HOLD: begin
                st_d = ST_IDLE;
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sram_ctrl_pins.sv
// Pin stage: registers every memory-side output so that strobes leave
// the block glitch-free. It latches the address and write data when a
// request is taken, and captures read data on the capture edge.
// Assumes the command reflects the levels wanted for the next clock.
module sram_ctrl_pins
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  pin_cmd_t          cmd_nxt,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr,
    output logic              ce_n,
    output logic              ce,
    output logic              we_n,
    output logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    // Address and write data are latched once per request and stay stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            dq_out <= '0;
        end else if (accept) begin
            addr <= req_addr;
            if (req_write) begin
                dq_out <= req_wdata;
            end
        end
    end

    // Strobe and enable levels, inverted to pin polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            ce    <= 1'b0;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            ce_n  <= ~cmd_nxt.sel;
            ce    <= cmd_nxt.sel;
            we_n  <= ~cmd_nxt.we_low;
            oe_n  <= ~cmd_nxt.oe_low;
            dq_oe <= cmd_nxt.drive;
        end
    end

    // Read capture with a one-clock valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) begin
                rdata <= dq_in;
            end
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
// Top of the asynchronous static RAM controller. It derives whole-clock
// interval counts from the speed grade and the clock period, then joins
// the sequencer and the pin stage. Assumes one request at a time and an
// external bus whose drive and receive halves are kept apart.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int SLOW_GRADE = 0,
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int T_RC  = grade_ns(SLOW_GRADE, 70, 100);
    localparam int T_AA  = grade_ns(SLOW_GRADE, 70, 100);
    localparam int T_ACS = grade_ns(SLOW_GRADE, 70, 100);
    localparam int T_OE  = grade_ns(SLOW_GRADE, 35, 50);
    localparam int T_OFF = grade_ns(SLOW_GRADE, 35, 40);
    localparam int T_WC  = grade_ns(SLOW_GRADE, 70, 100);
    localparam int T_CW  = grade_ns(SLOW_GRADE, 70, 100);
    localparam int T_AW  = grade_ns(SLOW_GRADE, 70, 100);
    localparam int T_WP  = grade_ns(SLOW_GRADE, 35, 50);
    localparam int T_DW  = grade_ns(SLOW_GRADE, 30, 40);

    localparam int ACC_CLK  = imax(1, imax(imax(clk_ceil(T_AA, CLK_NS), clk_ceil(T_ACS, CLK_NS)),
                                           imax(clk_ceil(T_OE, CLK_NS), clk_ceil(T_RC, CLK_NS))));
    localparam int TURN_CLK = imax(1, clk_ceil(T_OFF, CLK_NS));
    localparam int WLOW_CLK = imax(1, imax(imax(clk_ceil(T_WP, CLK_NS), clk_ceil(T_DW, CLK_NS)),
                                           imax(imax(clk_ceil(T_CW, CLK_NS) - 1, clk_ceil(T_AW, CLK_NS) - 1),
                                                clk_ceil(T_WC, CLK_NS) - 2)));
    localparam int CNT_MAX  = imax(ACC_CLK, imax(TURN_CLK, WLOW_CLK));
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    pin_cmd_t cmd_nxt;
    logic     accept;
    logic     capture;

    sram_ctrl_seq #(
        .ACC_CLK  (ACC_CLK),
        .TURN_CLK (TURN_CLK),
        .WLOW_CLK (WLOW_CLK),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .ready     (req_ready),
        .accept    (accept),
        .cmd_nxt   (cmd_nxt),
        .capture   (capture)
    );

    sram_ctrl_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cmd_nxt   (cmd_nxt),
        .capture   (capture),
        .dq_in     (mem_dq_in),
        .addr      (mem_addr),
        .ce_n      (mem_ce_n),
        .ce        (mem_ce),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .dq_out    (mem_dq_out),
        .dq_oe     (mem_dq_oe),
        .rdata     (rsp_rdata),
        .rvalid    (rsp_valid)
    );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
// Protocol checker for the controller's ports, bound into the top.
// It keeps a saturating count of clocks since output enable last went
// low, which it uses to judge the bus turnaround gap.
module sram_async_ctrl_chk #(
    parameter int TURN_CLK = 4,
    parameter int ADDR_W   = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    int gap_q;

    // Clocks elapsed with output enable high, saturating at the gap length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= TURN_CLK;
        end else if (!mem_oe_n) begin
            gap_q <= 0;
        end else if (gap_q < TURN_CLK) begin
            gap_q <= gap_q + 1;
        end
    end

    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_read_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_bus_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (gap_q >= TURN_CLK));

    p_we_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && !mem_ce_n));

    p_drive_oe_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_addr_we_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n)));

    p_enable_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n != mem_ce);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .TURN_CLK (TURN_CLK),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // 70 ns grade figures and the clock counts the requirements call for.
    localparam int NS_AA = 70, NS_ACS = 70, NS_OE = 35, NS_OFF = 35;
    localparam int NS_WP = 35, NS_DW = 30, NS_CW = 70, NS_AW = 70;
    localparam int E_ACC  = 7;
    localparam int E_TURN = cdiv(NS_OFF, 10);
    localparam int E_WLOW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  rsp_rdata;
    logic        rsp_valid;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    always #5 clk = ~clk;

    sram_async_ctrl u_sram_async_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .rsp_rdata  (rsp_rdata),
        .rsp_valid  (rsp_valid),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_ce     (mem_ce),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural memory with nanosecond timing checkers.
    function automatic logic [7:0] init_byte(input logic [17:0] a);
        return a[7:0] ^ {2'b00, a[17:12]} ^ 8'h5A;
    endfunction

    logic [7:0] mem_m [int];
    logic [7:0] ref_m [int];
    logic [7:0] rd_val = 8'h00;
    longint t_addr = 0, t_sel = 0, t_oe = 0, t_off = -1000, t_data = 0, t_wefall = 0;

    wire sel    = !mem_ce_n && mem_ce;
    wire mem_en = sel && !mem_oe_n && mem_we_n;
    assign mem_dq_in = mem_dq_oe ? mem_dq_out : (mem_en ? rd_val : 8'h00);

    function automatic longint now();
        return longint'($time);
    endfunction

    function automatic logic [7:0] word_at(input logic [17:0] a);
        if (mem_m.exists(int'(a))) return mem_m[int'(a)];
        return init_byte(a);
    endfunction

    always @(mem_addr) begin
        t_addr = now();
        if (rst_n) chk(mem_we_n, "R8 address moved with write strobe low", 0, 1);
    end
    always @(posedge sel) t_sel = now();
    always @(negedge mem_oe_n) begin
        t_oe = now();
        if (rst_n) chk(!mem_dq_oe, "R7 output enable low while bus driven", 1, 0);
    end
    always @(negedge mem_en) t_off = now();
    always @(posedge mem_dq_oe) begin
        if (rst_n) chk(!mem_en && (now() - t_off >= NS_OFF), "R5 contention on drive-on", now() - t_off, NS_OFF);
    end
    always @(mem_dq_out or mem_dq_oe) begin
        if (rst_n && sel && !mem_we_n) chk(1'b0, "R6 data moved inside write window", 1, 0);
        t_data = now();
    end
    always @(negedge mem_we_n) t_wefall = now();
    always @(posedge mem_we_n) begin
        if (rst_n && sel) begin
            chk(mem_dq_oe, "R6 bus driven at write end", mem_dq_oe, 1);
            chk(now() - t_data >= NS_DW, "R6 data setup", now() - t_data, NS_DW);
            chk(now() - t_wefall >= NS_WP, "R6 strobe width", now() - t_wefall, NS_WP);
            chk(now() - t_sel >= NS_CW, "R6 select to end", now() - t_sel, NS_CW);
            chk(now() - t_addr >= NS_AW, "R6 address to end", now() - t_addr, NS_AW);
            mem_m[int'(mem_addr)] = mem_dq_out;
        end
    end
    always @(posedge rsp_valid) begin
        if (rst_n) begin
            chk(now() - t_addr >= NS_AA, "R4 sampled before address access", now() - t_addr, NS_AA);
            chk(now() - t_sel >= NS_ACS, "R4 sampled before select access", now() - t_sel, NS_ACS);
            chk(now() - t_oe >= NS_OE, "R4 sampled before enable access", now() - t_oe, NS_OE);
        end
    end
    // Output data is corrupt until every access time will have elapsed by the next edge.
    always @(negedge clk) begin
        if (mem_en && (now() + 5 - t_addr >= NS_AA) && (now() + 5 - t_sel >= NS_ACS)
            && (now() + 5 - t_oe >= NS_OE))
            rd_val = word_at(mem_addr);
        else
            rd_val = ~word_at(mem_addr);
    end

    // Cycle-by-cycle reference: one entry per clock after an accepting edge.
    typedef struct {
        bit ce_on, oe_low, we_low, drive, rvalid, chk_addr, chk_data;
        logic [17:0] addr;
        logic [7:0]  data;
    } exp_t;
    exp_t q[$];
    bit started = 1'b0;

    function automatic exp_t mk(bit ce_on, bit oe_low, bit we_low, bit drive, bit rvalid,
                                bit chk_addr, bit chk_data, logic [17:0] a, logic [7:0] d);
        exp_t e;
        e.ce_on = ce_on; e.oe_low = oe_low; e.we_low = we_low; e.drive = drive;
        e.rvalid = rvalid; e.chk_addr = chk_addr; e.chk_data = chk_data;
        e.addr = a; e.data = d;
        return e;
    endfunction

    always @(negedge clk) begin
        if (started) begin
            exp_t e;
            bit busy;
            busy = (q.size() > 0);
            if (busy) e = q.pop_front();
            else e = mk(0, 0, 0, 0, 0, 0, 0, '0, '0);
            chk(req_ready == !busy, "R2 ready", req_ready, !busy);
            chk(mem_ce_n == !e.ce_on && mem_ce == e.ce_on, "R9 enable pair", {mem_ce_n, mem_ce}, {!e.ce_on, e.ce_on});
            chk(mem_oe_n == !e.oe_low, "R3 output enable", mem_oe_n, !e.oe_low);
            chk(mem_we_n == !e.we_low, "R6 write strobe", mem_we_n, !e.we_low);
            chk(mem_dq_oe == e.drive, "R7 bus drive", mem_dq_oe, e.drive);
            chk(rsp_valid == e.rvalid, "R4 valid strobe", rsp_valid, e.rvalid);
            if (e.chk_addr) chk(mem_addr == e.addr, "R3 address", mem_addr, e.addr);
            if (e.chk_data && e.drive) chk(mem_dq_out == e.data, "R6 write data", mem_dq_out, e.data);
            if (e.chk_data && e.rvalid) chk(rsp_rdata == e.data, "R10 read data", rsp_rdata, e.data);
        end
    end

    // Present one request; with early set it is held while the block is busy.
    task automatic issue(input bit wr, input logic [17:0] a, input logic [7:0] d, input bit early);
        if (early) begin
            req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        if (wr) begin
            q.push_back(mk(1, 0, 0, 1, 0, 1, 1, a, d));
            for (int k = 0; k < E_WLOW; k++) q.push_back(mk(1, 0, 1, 1, 0, 1, 1, a, d));
            q.push_back(mk(1, 0, 0, 1, 0, 1, 1, a, d));
            ref_m[int'(a)] = d;
        end else begin
            logic [7:0] ev;
            ev = ref_m.exists(int'(a)) ? ref_m[int'(a)] : init_byte(a);
            for (int k = 0; k < E_ACC; k++) q.push_back(mk(1, 1, 0, 0, 0, 1, 0, a, '0));
            q.push_back(mk(0, 0, 0, 0, 1, 0, 1, a, ev));
            for (int k = 1; k < E_TURN; k++) q.push_back(mk(0, 0, 0, 0, 0, 0, 0, a, '0));
        end
        #1 req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle pin levels while reset is held.
        chk(req_ready, "R1 ready in reset", req_ready, 1);
        chk(mem_ce_n && !mem_ce, "R1 deselected in reset", {mem_ce_n, mem_ce}, 2);
        chk(mem_we_n && mem_oe_n, "R1 strobes high in reset", {mem_we_n, mem_oe_n}, 3);
        chk(!mem_dq_oe && !rsp_valid, "R1 no drive, no valid", {mem_dq_oe, rsp_valid}, 0);
        rst_n = 1'b1;
        started = 1'b1;
        repeat (2) @(negedge clk);

        issue(1, 18'h00000, 8'h3C, 0);
        issue(1, 18'h3FFFF, 8'hFF, 0);
        issue(0, 18'h3FFFF, 8'h00, 0);   // read after write
        issue(0, 18'h00000, 8'h00, 0);   // read after read
        issue(1, 18'h12345, 8'h00, 0);   // write right after read: turnaround
        issue(0, 18'h12345, 8'h00, 0);
        issue(0, 18'h00777, 8'h00, 0);   // never written
        issue(1, 18'h00100, 8'hA5, 1);   // held during the previous read (R2)
        issue(0, 18'h00100, 8'h00, 1);   // held during the previous write
        for (int i = 0; i < 8; i++) begin
            issue(1, 18'(i * 18'h04A31), 8'(i * 37 + 1), i[0]);
        end
        for (int i = 7; i >= 0; i--) begin
            issue(0, 18'(i * 18'h04A31), 8'h00, i[1]);
        end
        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R2 schedule drained", q.size(), 0);
        finish_run();
    end
endmodule